// File: doc/BRIEF.md
# Eight-Point Pipelined Radix-2² FFT

The block is a forward 8-point discrete Fourier transform engine built for streaming use. A whole vector of eight complex samples enters in one cycle on two packed buses, real and imaginary, qualified by `valid_i`. The eight frequency bins leave together on matching packed buses in natural order, qualified by `valid_o`. A new vector may be presented on every clock. Each vector comes out exactly three cycles after it was accepted.

The computation uses decimation in frequency, factored with a radix-2² index map. The first column forms sums and differences of samples four apart. The second column pairs values two apart. In the difference half of that column, the partner is rotated by -j, which costs only a swap of the real and imaginary parts and a sign change at the adders. Ahead of the last column, one lane takes a further free -j rotation. Two lanes are multiplied by the odd eighth roots of unity, which is the only place a constant multiplier is used. The final sum and difference pairs are wired straight to their natural-order bin positions.

Samples are signed two's complement. Each butterfly column widens the word by one guard bit, so a 16-bit input produces 19-bit bins. The data registers have no reset. Only the three valid flags are cleared.

Top module: `fft8_r22`

## Requirements
- R1: For every accepted vector, bin k on each component equals the 8-point transform X(k) = Σ x(n)·e^(−j2πnk/8) within 2 LSB. The rounding error comes only from the 1/√2 twiddle constant.
- R2: Sample n is taken from bits [n·16 +: 16] of `x_re_i`/`x_im_i`. Bin k is placed at bits [k·19 +: 19] of `y_re_o`/`y_im_o`, in natural order (0..7) with no bit reversal. An impulse at sample 1 of value A must give bin k = A·e^(−jπk/4).
- R3: Bins 0 and 4 are exact, with no rounding. Bin 0 is the plain sum of the eight samples. Bin 4 is the sum with the odd-indexed samples negated.
- R4: Real samples 1,0,1,0,1,0,1,0 give bins 0 and 4 equal to 4. All other bins, and all imaginary parts, are 0.
- R5: `valid_o` is high exactly three rising edges after `valid_i` was sampled high. That output cycle carries the bins of that vector. Back-to-back vectors, one per cycle, come out back to back and in order.
- R6: A cycle with `valid_i` low produces no output strobe three cycles later, whatever data is on the input buses.
- R7: A low `rst_ni` clears all three valid flags at once, without waiting for a clock. `valid_o` is low during reset. Vectors that were in flight when reset arrived never appear after reset is released.
- R8: Bins are signed two's complement of width 16+3. All eight real samples at −32768 give bin 0 = −262144, with no overflow, and all other bins 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset of the valid flags |
| valid_i | input | 1 | Input vector qualifier |
| x_re_i | input | 128 | Real parts of samples 0..7, sample n at [n·16 +: 16] |
| x_im_i | input | 128 | Imaginary parts of samples 0..7 |
| valid_o | output | 1 | Output vector qualifier, three cycles after `valid_i` |
| y_re_o | output | 152 | Real parts of bins 0..7, bin k at [k·19 +: 19] |
| y_im_o | output | 152 | Imaginary parts of bins 0..7 |

## Verification
The alternating pattern, the DC vector and the impulse at sample 0 each excite only bins that need no twiddle multiply, so they pin down the adder columns exactly. An impulse at sample 1 gives a distinct phase in every bin, which exposes any twiddle sign error, wrong root or bin-order mistake that the symmetric patterns would hide. Two irregular complex vectors, one with large mixed-sign values, exercise all four rotation paths at once. A vector at full negative scale checks the guard-bit growth at the extreme. Directed sequences cover idle cycles with garbage on the data buses and a reset that lands while three vectors are in flight.

// File: rtl/fft8_pkg.sv
package fft8_pkg;
  localparam int NPT  = 8;
  localparam int HALF = NPT / 2;

  // reverse the low nb bits of v
  function automatic int rev_bits(input int v, input int nb);
    int r;
    r = 0;
    for (int i = 0; i < nb; i++)
      if (v[i]) r = r | (1 << (nb - 1 - i));
    return r;
  endfunction
endpackage

// File: rtl/fft8_bfly.sv
module fft8_bfly #(
  parameter int IW  = 16,
  parameter bit ROT = 1'b0  // rotate b by -j before combining
) (
  input  logic signed [IW-1:0] a_re_i,
  input  logic signed [IW-1:0] a_im_i,
  input  logic signed [IW-1:0] b_re_i,
  input  logic signed [IW-1:0] b_im_i,
  output logic signed [IW:0]   s_re_o,
  output logic signed [IW:0]   s_im_o,
  output logic signed [IW:0]   d_re_o,
  output logic signed [IW:0]   d_im_o
);
  logic signed [IW:0] ar, ai, br, bi;
  assign ar = {a_re_i[IW-1], a_re_i};
  assign ai = {a_im_i[IW-1], a_im_i};
  assign br = {b_re_i[IW-1], b_re_i};
  assign bi = {b_im_i[IW-1], b_im_i};

  if (ROT) begin : g_rot
    // -j*b = (bi, -br): folded into the adders, no negation overflow
    assign s_re_o = ar + bi;
    assign s_im_o = ai - br;
    assign d_re_o = ar - bi;
    assign d_im_o = ai + br;
  end else begin : g_plain
    assign s_re_o = ar + br;
    assign s_im_o = ai + bi;
    assign d_re_o = ar - br;
    assign d_im_o = ai - bi;
  end
endmodule

// File: rtl/fft8_twiddle.sv
module fft8_twiddle #(
  parameter int W    = 18,
  parameter int FRAC = 15,
  parameter bit ODD3 = 1'b0  // 0: W8^1, 1: W8^3
) (
  input  logic signed [W-1:0] re_i,
  input  logic signed [W-1:0] im_i,
  output logic signed [W-1:0] re_o,
  output logic signed [W-1:0] im_o
);
  localparam int  SW      = W + 2;
  localparam int  CW      = FRAC + 2;
  localparam int  PW      = SW + CW;
  localparam real INV_RT2 = 0.7071067811865476;
  localparam logic signed [CW-1:0] COEF = CW'(int'(INV_RT2 * (2.0 ** FRAC)));
  localparam logic signed [PW-1:0] RND  = PW'(1) << (FRAC - 1);

  logic signed [SW-1:0] a, b, sum_ab, dif_ba, xr, xi;
  logic signed [PW-1:0] pr, pi;

  assign a      = SW'(re_i);
  assign b      = SW'(im_i);
  assign sum_ab = a + b;
  assign dif_ba = b - a;

  if (ODD3) begin : g_w3
    // (a+jb)(-1-j)/sqrt2
    assign xr = dif_ba;
    assign xi = -sum_ab;
  end else begin : g_w1
    // (a+jb)(1-j)/sqrt2
    assign xr = sum_ab;
    assign xi = dif_ba;
  end

  assign pr   = PW'(xr) * PW'(COEF) + RND;
  assign pi   = PW'(xi) * PW'(COEF) + RND;
  assign re_o = W'(pr >>> FRAC);
  assign im_o = W'(pi >>> FRAC);
endmodule

// File: rtl/fft8_r22.sv
module fft8_r22 import fft8_pkg::*; #(
  parameter  int DATA_W  = 16,
  parameter  int TW_FRAC = 15,
  localparam int OUT_W   = DATA_W + 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [NPT*DATA_W-1:0]   x_re_i,
  input  logic [NPT*DATA_W-1:0]   x_im_i,
  output logic                    valid_o,
  output logic [NPT*OUT_W-1:0]    y_re_o,
  output logic [NPT*OUT_W-1:0]    y_im_o
);
  localparam int W1 = DATA_W + 1;
  localparam int W2 = DATA_W + 2;

  logic signed [DATA_W-1:0] x_re [NPT], x_im [NPT];
  logic signed [W1-1:0]     c1_re [NPT], c1_im [NPT], r1_re [NPT], r1_im [NPT];
  logic signed [W2-1:0]     c2_re [NPT], c2_im [NPT], r2_re [NPT], r2_im [NPT];
  logic signed [OUT_W-1:0]  c3_re [NPT], c3_im [NPT], r3_re [NPT], r3_im [NPT];
  logic [2:0]               vld_q;

  for (genvar n = 0; n < NPT; n++) begin : g_io
    assign x_re[n] = x_re_i[n*DATA_W +: DATA_W];
    assign x_im[n] = x_im_i[n*DATA_W +: DATA_W];
    assign y_re_o[n*OUT_W +: OUT_W] = r3_re[n];
    assign y_im_o[n*OUT_W +: OUT_W] = r3_im[n];
  end

  // column 1: pairs four apart; sums to lanes 0..3, differences to 4..7
  for (genvar n = 0; n < HALF; n++) begin : g_col1
    fft8_bfly #(.IW(DATA_W), .ROT(1'b0)) u_bf (
      .a_re_i(x_re[n]),      .a_im_i(x_im[n]),
      .b_re_i(x_re[n+HALF]), .b_im_i(x_im[n+HALF]),
      .s_re_o(c1_re[n]),      .s_im_o(c1_im[n]),
      .d_re_o(c1_re[n+HALF]), .d_im_o(c1_im[n+HALF]));
  end

  // column 2: pairs two apart inside each half; odd half rotates by -j
  // lane index afterwards = 4*k1 + 2*k2 + n3
  for (genvar h = 0; h < 2; h++) begin : g_half
    for (genvar m = 0; m < 2; m++) begin : g_pair
      fft8_bfly #(.IW(W1), .ROT(h == 1)) u_bf (
        .a_re_i(r1_re[4*h+m]),   .a_im_i(r1_im[4*h+m]),
        .b_re_i(r1_re[4*h+m+2]), .b_im_i(r1_im[4*h+m+2]),
        .s_re_o(c2_re[4*h+m]),   .s_im_o(c2_im[4*h+m]),
        .d_re_o(c2_re[4*h+m+2]), .d_im_o(c2_im[4*h+m+2]));
    end
  end

  // column 3: twiddle W8^(k1+2k2) on the n3=1 lane, then last butterfly
  for (genvar g = 0; g < HALF; g++) begin : g_col3
    localparam int KB = rev_bits(g, 2);
    logic signed [W2-1:0] b_re, b_im;
    if (g >= 2) begin : g_tw
      fft8_twiddle #(.W(W2), .FRAC(TW_FRAC), .ODD3(g == 3)) u_tw (
        .re_i(r2_re[2*g+1]), .im_i(r2_im[2*g+1]),
        .re_o(b_re),         .im_o(b_im));
    end else begin : g_pass
      assign b_re = r2_re[2*g+1];
      assign b_im = r2_im[2*g+1];
    end
    // g==1 carries W8^2 = -j, done in the adders
    fft8_bfly #(.IW(W2), .ROT(g == 1)) u_bf (
      .a_re_i(r2_re[2*g]),  .a_im_i(r2_im[2*g]),
      .b_re_i(b_re),        .b_im_i(b_im),
      .s_re_o(c3_re[KB]),   .s_im_o(c3_im[KB]),
      .d_re_o(c3_re[KB+4]), .d_im_o(c3_im[KB+4]));
  end

  always_ff @(posedge clk_i) begin
    r1_re <= c1_re;
    r1_im <= c1_im;
    r2_re <= c2_re;
    r2_im <= c2_im;
    r3_re <= c3_re;
    r3_im <= c3_im;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[1:0], valid_i};
  end

  assign valid_o = vld_q[2];
endmodule

// File: rtl/fft8_r22_chk.sv
module fft8_r22_chk import fft8_pkg::*; #(
  parameter  int DATA_W = 16,
  localparam int OUT_W  = DATA_W + 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic [NPT*DATA_W-1:0] x_re_i,
  input logic [NPT*DATA_W-1:0] x_im_i,
  input logic                  valid_o,
  input logic [NPT*OUT_W-1:0]  y_re_o,
  input logic [NPT*OUT_W-1:0]  y_im_o
);
  function automatic logic signed [OUT_W-1:0] fold(input logic [NPT*DATA_W-1:0] v,
                                                   input bit alt);
    logic signed [OUT_W-1:0] acc;
    logic signed [DATA_W-1:0] e;
    acc = '0;
    for (int n = 0; n < NPT; n++) begin
      e = v[n*DATA_W +: DATA_W];
      if (alt && n[0]) acc = acc - OUT_W'(e);
      else             acc = acc + OUT_W'(e);
    end
    return acc;
  endfunction

  logic signed [OUT_W-1:0] sum_re, sum_im, alt_re, alt_im;
  logic [1:0] warm_q;

  always_comb begin
    sum_re = fold(x_re_i, 1'b0);
    sum_im = fold(x_im_i, 1'b0);
    alt_re = fold(x_re_i, 1'b1);
    alt_im = fold(x_im_i, 1'b1);
  end

  // edges seen since reset release, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R5
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  // R3
  bin0_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && valid_o) |->
      (y_re_o[0 +: OUT_W] == $past(sum_re, 3) && y_im_o[0 +: OUT_W] == $past(sum_im, 3)));

  // R3
  bin4_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && valid_o) |->
      (y_re_o[4*OUT_W +: OUT_W] == $past(alt_re, 3) &&
       y_im_o[4*OUT_W +: OUT_W] == $past(alt_im, 3)));

  // R7
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |-> !valid_o);
endmodule

bind fft8_r22 fft8_r22_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/fft8_r22_tb.sv
`timescale 1ns/1ps
module fft8_r22_tb;
  localparam int  DW  = 16;
  localparam int  OW  = DW + 3;
  localparam int  NP  = 8;
  localparam int  NV  = 7;
  localparam real TCK = 8.0;
  localparam real PI  = 3.14159265358979323846;

  localparam int TBL_RE [NV][NP] = '{
    '{1, 0, 1, 0, 1, 0, 1, 0},
    '{1000, 0, 0, 0, 0, 0, 0, 0},
    '{100, 100, 100, 100, 100, 100, 100, 100},
    '{0, 1000, 0, 0, 0, 0, 0, 0},
    '{300, -1200, 4500, -70, 2222, -3333, 17, 900},
    '{-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768},
    '{10000, -10000, 7000, 3000, -8000, 500, 9000, -2500}
  };
  localparam int TBL_IM [NV][NP] = '{
    '{0, 0, 0, 0, 0, 0, 0, 0},
    '{0, 0, 0, 0, 0, 0, 0, 0},
    '{0, 0, 0, 0, 0, 0, 0, 0},
    '{0, 0, 0, 0, 0, 0, 0, 0},
    '{-500, 800, 0, 1234, -4321, 60, -9, 2500},
    '{0, 0, 0, 0, 0, 0, 0, 0},
    '{4000, -6000, 10000, -3000, 2000, -7000, 0, 8000}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              valid_i;
  logic [NP*DW-1:0]  x_re_i, x_im_i;
  logic              valid_o;
  logic [NP*OW-1:0]  y_re_o, y_im_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  real exp_re [NV][NP];
  real exp_im [NV][NP];

  fft8_r22 u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .x_re_i(x_re_i), .x_im_i(x_im_i),
    .valid_o(valid_o), .y_re_o(y_re_o), .y_im_o(y_im_o));

  always #(TCK/2.0) clk_i = ~clk_i;

  initial begin
    #(TCK * 200000.0);
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
    $finish;
  end

  function automatic real rabs(input real r);
    return (r < 0.0) ? -r : r;
  endfunction

  task automatic chk_int(input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic chk_real(input string tag, input string what, input int act,
                          input real expv, input real tol);
    n_chk++;
    if (rabs(real'(act) - expv) > tol) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0.3f", tag, what, act, expv);
    end
  endtask

  function automatic int bin_re(input int k);
    logic signed [OW-1:0] v;
    v = y_re_o[k*OW +: OW];
    return int'(v);
  endfunction

  function automatic int bin_im(input int k);
    logic signed [OW-1:0] v;
    v = y_im_o[k*OW +: OW];
    return int'(v);
  endfunction

  task automatic drive_vec(input int i, input logic v);
    for (int n = 0; n < NP; n++) begin
      x_re_i[n*DW +: DW] = DW'(TBL_RE[i][n]);
      x_im_i[n*DW +: DW] = DW'(TBL_IM[i][n]);
    end
    valid_i = v;
  endtask

  task automatic check_vec(input int i);
    string tag;
    real   tol;
    for (int k = 0; k < NP; k++) begin
      if (i == 0)                tag = "R4";
      else if (i == 5)           tag = "R8";
      else if (k == 0 || k == 4) tag = "R3";
      else if (i == 3)           tag = "R2";
      else                       tag = "R1";
      tol = (i == 0 || i == 5 || k == 0 || k == 4) ? 0.5 : 2.0;
      chk_real(tag, $sformatf("vec %0d bin %0d re", i, k), bin_re(k), exp_re[i][k], tol);
      chk_real(tag, $sformatf("vec %0d bin %0d im", i, k), bin_im(k), exp_im[i][k], tol);
    end
  endtask

  initial begin
    // reference transform
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < NP; k++) begin
        real sr, si, th;
        sr = 0.0;
        si = 0.0;
        for (int n = 0; n < NP; n++) begin
          th = 2.0 * PI * real'(n * k) / real'(NP);
          sr = sr + real'(TBL_RE[i][n]) * $cos(th) + real'(TBL_IM[i][n]) * $sin(th);
          si = si + real'(TBL_IM[i][n]) * $cos(th) - real'(TBL_RE[i][n]) * $sin(th);
        end
        exp_re[i][k] = sr;
        exp_im[i][k] = si;
      end
    end

    rst_ni  = 1'b0;
    valid_i = 1'b0;
    x_re_i  = '0;
    x_im_i  = '0;
    repeat (3) @(negedge clk_i);
    chk_int("R7", "valid_o during reset", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_int("R7", "valid_o after release", int'(valid_o), 0);

    // table walk: back-to-back vectors, outputs compared three cycles later
    for (int c = 0; c < NV + 3; c++) begin
      @(negedge clk_i);
      if (c >= 3) begin
        chk_int("R5", $sformatf("valid_o for vec %0d", c - 3), int'(valid_o), 1);
        check_vec(c - 3);
      end else begin
        chk_int("R5", $sformatf("valid_o early cycle %0d", c), int'(valid_o), 0);
      end
      if (c < NV) drive_vec(c, 1'b1);
      else        drive_vec(6, 1'b0);
    end

    // idle cycles with garbage on the buses
    for (int c = 0; c < 6; c++) begin
      @(negedge clk_i);
      chk_int("R6", $sformatf("valid_o idle cycle %0d", c), int'(valid_o), 0);
      drive_vec(c % NV, 1'b0);
    end

    // reset landing with three vectors in flight
    for (int c = 0; c < 3; c++) begin
      @(negedge clk_i);
      drive_vec(1, 1'b1);
    end
    @(negedge clk_i);
    chk_int("R5", "valid_o before mid reset", int'(valid_o), 1);
    chk_int("R5", "bin0 re before mid reset", bin_re(0), 1000);
    valid_i = 1'b0;
    #1;
    rst_ni = 1'b0;
    #1;
    chk_int("R7", "valid_o right after async reset", int'(valid_o), 0);
    @(negedge clk_i);
    chk_int("R7", "valid_o held in reset", int'(valid_o), 0);
    rst_ni = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk_i);
      chk_int("R7", $sformatf("stale vector after release cycle %0d", c), int'(valid_o), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule